// File: doc/BRIEF.md
# Debounced Four-Code Combination Lock

The block is a synchronous combination lock. A user sets a 4-bit value on four switches and confirms it with a pushbutton. Four confirmed values make one attempt. When the fourth value has been accepted, the lock compares the whole attempt with a fixed secret of four 4-bit values and raises either an unlock indication or a fail indication.

The pushbutton is active low. It passes through a two-flop synchronizer before any logic uses it. A free-running counter supplies a slow timing reference, which is one high bit of the counter. The rising edge of that bit becomes a one-cycle sample strobe. A press is accepted only when one strobe sees the button pressed and the strobe before it saw the button released. A held button therefore produces exactly one entry, and contact bounce between strobes is not seen. The tap index is a parameter: a chip build uses a high bit, and a simulation uses a low bit.

A wrong value still advances the entry count, so an observer cannot tell which value was wrong. A sticky flag records the mismatch. The result holds until the next accepted press, and that press starts a new attempt as its first entry.

Top module: `combo_lock`

## Requirements
- R1: While rst_ni is low and after it is released, unlock_o and fail_o are 0 and the lock waits for the first entry of an attempt.
- R2: btn_ni is active low (0 means pressed). It passes through two clock stages before it can affect anything, so the outputs cannot change earlier than the third rising clock edge after btn_ni falls.
- R3: The sample strobe is one clock wide. It occurs on each rising edge of bit TAP of a free-running counter that increments every clock, which is once every 2^(TAP+1) clocks.
- R4: A press is accepted on a strobe that sees the synchronized button pressed when the previous strobe saw it released. One physical press yields exactly one entry, however long it is held.
- R5: Entry k of an attempt (k = 1..4) is compared with SECRET bits [19-4k:16-4k]: entry 1 with [15:12] and entry 4 with [3:0].
- R6: If all four entries match, unlock_o=1 and fail_o=0 after the fourth accepted press.
- R7: A mismatch at any position does not end the attempt early: the outputs stay 0 through entries 1 to 3. After the fourth accepted press, fail_o=1 and unlock_o=0.
- R8: The unlock or fail result holds while no press is accepted. The next accepted press counts as entry 1 of a new attempt and clears both outputs.
- R9: unlock_o and fail_o are never 1 at the same time.
- R10: The outputs are registered. They change only on the clock edge that ends the cycle in which a press is accepted, which is no later than 2 + 2^(TAP+1) edges after btn_ni falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_i | input | 4 | Switch value offered as the current entry |
| btn_ni | input | 1 | Raw confirm pushbutton, low while pressed |
| unlock_o | output | 1 | Registered: the last attempt matched the secret |
| fail_o | output | 1 | Registered: the last attempt did not match |

## Verification
A result is due between the third edge and the (2 + 2^(TAP+1))-th edge after the button falls. The exact edge depends on where the next strobe lands. For the fourth entry the bench therefore checks twice. Two cycles after the fall it expects the previous outputs unchanged. It expects the new result only once eleven cycles have passed, with TAP set to 2. Entries are held and released for whole strobe periods. This lets every intermediate and final check sample a settled value at a falling clock edge, without predicting the strobe phase.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;
  typedef enum logic [1:0] {
    ST_ENTRY = 2'd0,
    ST_OPEN  = 2'd1,
    ST_FAIL  = 2'd2
  } lock_state_e;
endpackage

// File: rtl/combo_lock_sync.sv
module combo_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  output logic pressed_o
);
  logic [STAGES-1:0] chain_q;

  // reset value 1 = released (button idles high)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], btn_ni};
  end

  assign pressed_o = ~chain_q[STAGES-1];
endmodule

// File: rtl/combo_lock_strobe.sv
module combo_lock_strobe #(
  parameter int CNT_W = 32,
  parameter int TAP   = 22
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic strobe_o
);
  // bits above the tap feed nothing, so only TAP+1 bits are kept
  localparam int RUN_W = (TAP + 1 < CNT_W) ? TAP + 1 : CNT_W;

  logic [RUN_W-1:0] cnt_q;
  logic             tap_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      tap_prev_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_q + 1'b1;
      tap_prev_q <= cnt_q[RUN_W-1];
    end
  end

  assign strobe_o = cnt_q[RUN_W-1] & ~tap_prev_q;
endmodule

// File: rtl/combo_lock_press.sv
module combo_lock_press (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic pressed_i,
  output logic press_o
);
  logic last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_q <= 1'b0;
    else if (strobe_i) last_q <= pressed_i;
  end

  assign press_o = strobe_i & pressed_i & ~last_q;
endmodule

// File: rtl/combo_lock_fsm.sv
module combo_lock_fsm
  import combo_lock_pkg::*;
#(
  parameter int                     DIGITS  = 4,
  parameter int                     DIGIT_W = 4,
  parameter logic [DIGITS*DIGIT_W-1:0] SECRET = 16'h5A3C
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               press_i,
  input  logic [DIGIT_W-1:0] sw_i,
  output logic               unlock_o,
  output logic               fail_o
);
  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DIGITS - 1);

  lock_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  logic             miss_q;
  logic             unlock_q, fail_q;

  logic               start_w;
  logic [IDX_W-1:0]   cur_idx;
  logic               new_miss;
  logic               last_w;
  logic [DIGIT_W-1:0] exp_digit;

  always_comb begin
    start_w   = (state_q != ST_ENTRY);
    cur_idx   = start_w ? '0 : idx_q;
    // first entry compares with the most significant digit
    exp_digit = SECRET[(DIGITS - 1 - int'(cur_idx)) * DIGIT_W +: DIGIT_W];
    new_miss  = (start_w ? 1'b0 : miss_q) | (sw_i != exp_digit);
    last_w    = (cur_idx == LAST_IDX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_ENTRY;
      idx_q    <= '0;
      miss_q   <= 1'b0;
      unlock_q <= 1'b0;
      fail_q   <= 1'b0;
    end else if (press_i) begin
      unlock_q <= last_w & ~new_miss;
      fail_q   <= last_w & new_miss;
      if (last_w) begin
        state_q <= new_miss ? ST_FAIL : ST_OPEN;
        idx_q   <= '0;
        miss_q  <= 1'b0;
      end else begin
        state_q <= ST_ENTRY;
        idx_q   <= cur_idx + 1'b1;
        miss_q  <= new_miss;
      end
    end
  end

  assign unlock_o = unlock_q;
  assign fail_o   = fail_q;
endmodule

// File: rtl/combo_lock.sv
module combo_lock #(
  parameter int                  CNT_W  = 32,
  parameter int                  TAP    = 22,
  parameter logic [15:0]         SECRET = 16'h5A3C
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] sw_i,
  input  logic       btn_ni,
  output logic       unlock_o,
  output logic       fail_o
);
  logic pressed_w;
  logic strobe_w;
  logic press_w;

  combo_lock_sync #(.STAGES(2)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .btn_ni   (btn_ni),
    .pressed_o(pressed_w)
  );

  combo_lock_strobe #(.CNT_W(CNT_W), .TAP(TAP)) u_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_o(strobe_w)
  );

  combo_lock_press u_press (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_w),
    .pressed_i(pressed_w),
    .press_o  (press_w)
  );

  combo_lock_fsm #(.DIGITS(4), .DIGIT_W(4), .SECRET(SECRET)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .press_i (press_w),
    .sw_i    (sw_i),
    .unlock_o(unlock_o),
    .fail_o  (fail_o)
  );
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic strobe_w,
  input logic press_w,
  input logic unlock_o,
  input logic fail_o
);
  assert_no_overlap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(unlock_o && fail_o));

  assert_strobe_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_w |=> !strobe_w);

  assert_press_on_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_w |-> strobe_w);

  assert_press_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_w |=> !press_w);

  assert_unlock_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlock_o != $past(unlock_o)) |-> $past(press_w));

  assert_fail_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o != $past(fail_o)) |-> $past(press_w));
endmodule

bind combo_lock combo_lock_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .strobe_w(strobe_w),
  .press_w (press_w),
  .unlock_o(unlock_o),
  .fail_o  (fail_o)
);

// File: tb/combo_lock_tb_top.sv
module combo_lock_tb_top;
  localparam logic [15:0] KEY = 16'h5A3C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] sw = 4'h0;
  logic       btn_n = 1'b1;
  logic       unlock, fail;

  always #2.5 clk = ~clk;

  combo_lock #(.CNT_W(32), .TAP(2), .SECRET(KEY)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .sw_i    (sw),
    .btn_ni  (btn_n),
    .unlock_o(unlock),
    .fail_o  (fail)
  );

  typedef struct {
    logic  eu;
    logic  ef;
    string tag;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int   total = 0;
  int   bad = 0;
  bit   overlap = 1'b0;

  task automatic expect_out(input logic eu, input logic ef, input string tag);
    exp_t it;
    it.eu = eu; it.ef = ef; it.tag = tag;
    q.push_back(it);
    ->chk_ev;
    #1;
  endtask

  // monitor: pops expected results and compares them with the ports
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        total++;
        if (unlock !== it.eu || fail !== it.ef) begin
          bad++;
          $display("FAIL %s: unlock/fail=%b%b expected %b%b", it.tag, unlock, fail, it.eu, it.ef);
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && unlock && fail) overlap = 1'b1;

  // one physical press; on the last entry checks R2 sync delay and R10 latency
  task automatic enter(input logic [3:0] code, input int hold, input bit last,
                       input logic eu, input logic ef, input string tag);
    @(negedge clk);
    sw = code;
    btn_n = 1'b0;
    if (last) begin
      repeat (2) @(negedge clk);
      expect_out(1'b0, 1'b0, {"R2 no change before sync ", tag});
      repeat (9) @(negedge clk);
      expect_out(eu, ef, {"R10 latency ", tag});
      repeat (hold - 11) @(negedge clk);
    end else begin
      repeat (hold) @(negedge clk);
    end
    btn_n = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic attempt(input logic [15:0] seq, input logic eu, input logic ef, input string tag);
    for (int k = 0; k < 4; k++) begin
      logic [3:0] d;
      d = seq[15 - 4*k -: 4];
      if (k < 3) begin
        enter(d, 16, 1'b0, 1'b0, 1'b0, tag);
        expect_out(1'b0, 1'b0, {"R7/R8 outputs low mid-attempt ", tag});
      end else begin
        enter(d, 16, 1'b1, eu, ef, tag);
        expect_out(eu, ef, {"result ", tag});
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_out(1'b0, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    expect_out(1'b0, 1'b0, "R1 after reset");

    attempt(KEY, 1'b1, 1'b0, "R6 R5 correct code");
    attempt(16'hCA35 ^ 16'h0000, 1'b0, 1'b1, "R5 R7 wrong order");
    attempt(KEY ^ 16'h1000, 1'b0, 1'b1, "R7 wrong digit 1");
    attempt(KEY ^ 16'h0200, 1'b0, 1'b1, "R7 wrong digit 2");
    attempt(KEY ^ 16'h0030, 1'b0, 1'b1, "R7 wrong digit 3");
    attempt(KEY ^ 16'h0004, 1'b0, 1'b1, "R7 wrong digit 4");
    attempt(KEY, 1'b1, 1'b0, "R6 correct after failures");

    // R8: result holds while idle
    repeat (200) @(negedge clk);
    expect_out(1'b1, 1'b0, "R8 open holds while idle");

    // R4: long hold on one entry counts once
    enter(KEY[15:12], 16, 1'b0, 1'b0, 1'b0, "R4");
    expect_out(1'b0, 1'b0, "R8 next press clears outputs");
    enter(KEY[11:8], 120, 1'b0, 1'b0, 1'b0, "R4");
    expect_out(1'b0, 1'b0, "R4 long hold mid-attempt");
    enter(KEY[7:4], 16, 1'b0, 1'b0, 1'b0, "R4");
    enter(KEY[3:0], 16, 1'b1, 1'b1, 1'b0, "R4 long hold counted once");
    expect_out(1'b1, 1'b0, "R4 R3 result after long hold");

    attempt(KEY ^ 16'h0001, 1'b0, 1'b1, "R7 fail");
    repeat (150) @(negedge clk);
    expect_out(1'b0, 1'b1, "R8 fail holds while idle");

    // reset in the middle of an attempt
    enter(KEY[15:12], 16, 1'b0, 1'b0, 1'b0, "R1");
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    attempt(KEY, 1'b1, 1'b0, "R1 fresh attempt after reset");

    total++;
    if (overlap) begin
      bad++;
      $display("FAIL R9: unlock/fail=11 seen expected never both");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run=hung expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule